// File: doc/BRIEF.md
# DDS Phase Accumulator with Clear Controls

This block keeps the running phase of a direct digital synthesizer. On each clock it adds the active frequency tuning word to a phase register, and the register wraps modulo 2^PHASE_W. A new tuning word is written into a staging register at any time. It takes effect only when an update strobe moves it into the active register.

Two clear paths are available. The first is a one-cycle zeroing of the phase that is tied to the update strobe and enabled by a control bit. The second is a level-held clear that pins the phase at zero for as long as it is asserted. A power-down input freezes the phase and the active word in place. An output stage applies a quarter-turn offset when sine is selected, so that a downstream cosine lookup produces a sine. The stage also passes the selection along.

Top module: `dds_phase_acc`

## Requirements
- R1: After reset the phase register, the staging word and the active word are all zero, and `phase_o` is 0 while `sine_sel_i` is 0.
- R2: On each clock edge with power-down low, level clear low, and no update that has auto-clear enabled, the phase becomes (phase + active word) mod 2^PHASE_W.
- R3: `ftw_wr_i` loads `ftw_i` into the staging word on the next edge. This has no effect on the phase until an update transfers it.
- R4: On an edge where `update_i` is high and power-down is low, the staging word is copied into the active word. That same edge still accumulates with the previous word, and the new word is used from the following edge onward.
- R5: With `auto_clr_en_i` at 0, an update leaves the phase stepping normally and does not reset it.
- R6: With `auto_clr_en_i` at 1, an update edge loads zero into the phase instead of stepping. The next edge steps from zero by the new word.
- R7: While `clr_hold_i` is 1 and power-down is low, the phase is loaded with zero on every edge. This takes priority over auto-clear and accumulation. After release, the phase steps from zero.
- R8: With `sine_sel_i` at 0 (cosine), `phase_o` equals the phase register and `sine_sel_o` is 0.
- R9: With `sine_sel_i` at 1 (sine), `phase_o` equals (phase − 0x4000_0000) mod 2^32 and `sine_sel_o` is 1.
- R10: While `pwr_down_i` is 1, the phase and the active word hold their values, and updates and clears are ignored. Staging-word writes are still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ftw_wr_i | input | 1 | Write strobe for the staging tuning word |
| ftw_i | input | PHASE_W | Tuning word to stage |
| update_i | input | 1 | Transfers the staging word into the active word |
| auto_clr_en_i | input | 1 | Enables a one-cycle phase zeroing on update |
| clr_hold_i | input | 1 | Level clear that holds the phase at zero |
| sine_sel_i | input | 1 | 0 selects cosine, 1 selects sine |
| pwr_down_i | input | 1 | Freezes the phase and the active word |
| phase_o | output | PHASE_W | Phase word after the sine/cosine offset |
| sine_sel_o | output | 1 | Forwarded sine/cosine selection |

## Verification
All state changes land on the clock edge that samples the control inputs. The phase, the staging word and the active word therefore each move exactly one edge after their stimulus, and `phase_o` follows the phase register combinationally. The bench drives inputs on the falling edge and advances a reference model at the rising edge. It compares `phase_o` and `sine_sel_o` at the next falling edge, so every check falls on the first cycle in which a result is due. A change to the tuning word is observed two edges after the update: one edge for the transfer, one for the first step with the new word. The bench checks both edges of that sequence separately.

// File: rtl/dds_pkg.sv
package dds_pkg;
  typedef enum logic [1:0] {
    ACC_FREEZE = 2'd0,
    ACC_ZERO   = 2'd1,
    ACC_STEP   = 2'd2
  } acc_op_e;
endpackage

// File: rtl/dds_acc_ctrl.sv
module dds_acc_ctrl
  import dds_pkg::*;
(
  input  logic    pwr_down_i,
  input  logic    clr_hold_i,
  input  logic    update_i,
  input  logic    auto_clr_en_i,
  output acc_op_e acc_op_o,
  output logic    act_load_o
);
  // priority: power-down > level clear > auto-clear > step
  always_comb begin
    if (pwr_down_i)                      acc_op_o = ACC_FREEZE;
    else if (clr_hold_i)                 acc_op_o = ACC_ZERO;
    else if (update_i && auto_clr_en_i)  acc_op_o = ACC_ZERO;
    else                                 acc_op_o = ACC_STEP;
  end

  assign act_load_o = update_i && !pwr_down_i;
endmodule

// File: rtl/dds_ftw_regs.sv
module dds_ftw_regs #(
  parameter int unsigned PHASE_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [PHASE_W-1:0] ftw_i,
  input  logic               load_i,
  output logic [PHASE_W-1:0] hold_o,
  output logic [PHASE_W-1:0] act_o
);
  logic [PHASE_W-1:0] hold_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hold_q <= '0;
    else if (wr_i) hold_q <= ftw_i;
  end

  // active takes the staged value present before this edge's write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_q <= '0;
    else if (load_i) act_q <= hold_q;
  end

  assign hold_o = hold_q;
  assign act_o  = act_q;
endmodule

// File: rtl/dds_acc_core.sv
module dds_acc_core
  import dds_pkg::*;
#(
  parameter int unsigned PHASE_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  acc_op_e            op_i,
  input  logic [PHASE_W-1:0] step_i,
  output logic [PHASE_W-1:0] acc_o
);
  logic [PHASE_W-1:0] acc_q, acc_d;

  always_comb begin
    unique case (op_i)
      ACC_ZERO: acc_d = '0;
      ACC_STEP: acc_d = acc_q + step_i;
      default:  acc_d = acc_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/dds_phase_map.sv
module dds_phase_map #(
  parameter int unsigned PHASE_W = 32
) (
  input  logic [PHASE_W-1:0] acc_i,
  input  logic               sine_sel_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic               sine_sel_o
);
  localparam logic [PHASE_W-1:0] QUARTER = {2'b01, {(PHASE_W-2){1'b0}}};

  // sine = cosine shifted back a quarter turn
  assign phase_o    = sine_sel_i ? (acc_i - QUARTER) : acc_i;
  assign sine_sel_o = sine_sel_i;
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc
  import dds_pkg::*;
#(
  parameter int unsigned PHASE_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ftw_wr_i,
  input  logic [PHASE_W-1:0] ftw_i,
  input  logic               update_i,
  input  logic               auto_clr_en_i,
  input  logic               clr_hold_i,
  input  logic               sine_sel_i,
  input  logic               pwr_down_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic               sine_sel_o
);
  acc_op_e            acc_op;
  logic               act_load;
  logic [PHASE_W-1:0] hold_ftw, act_ftw, acc_q;

  dds_acc_ctrl u_ctrl (
    .pwr_down_i   (pwr_down_i),
    .clr_hold_i   (clr_hold_i),
    .update_i     (update_i),
    .auto_clr_en_i(auto_clr_en_i),
    .acc_op_o     (acc_op),
    .act_load_o   (act_load)
  );

  dds_ftw_regs #(.PHASE_W(PHASE_W)) u_ftw (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (ftw_wr_i),
    .ftw_i (ftw_i),
    .load_i(act_load),
    .hold_o(hold_ftw),
    .act_o (act_ftw)
  );

  dds_acc_core #(.PHASE_W(PHASE_W)) u_core (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .op_i  (acc_op),
    .step_i(act_ftw),
    .acc_o (acc_q)
  );

  dds_phase_map #(.PHASE_W(PHASE_W)) u_map (
    .acc_i     (acc_q),
    .sine_sel_i(sine_sel_i),
    .phase_o   (phase_o),
    .sine_sel_o(sine_sel_o)
  );
endmodule

// File: rtl/dds_phase_acc_chk.sv
module dds_phase_acc_chk #(
  parameter int unsigned PHASE_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ftw_wr_i,
  input logic [PHASE_W-1:0] ftw_i,
  input logic               update_i,
  input logic               auto_clr_en_i,
  input logic               clr_hold_i,
  input logic               pwr_down_i,
  input logic [PHASE_W-1:0] hold_ftw,
  input logic [PHASE_W-1:0] act_ftw,
  input logic [PHASE_W-1:0] acc_q
);
  AST_ACC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_down_i && !clr_hold_i && !(update_i && auto_clr_en_i))
      |=> acc_q == $past(acc_q) + $past(act_ftw)); // R2
  AST_HOLD_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ftw_wr_i |=> hold_ftw == $past(ftw_i)); // R3
  AST_ACT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_i && !pwr_down_i) |=> act_ftw == $past(hold_ftw)); // R4
  AST_AUTO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_i && auto_clr_en_i && !pwr_down_i) |=> acc_q == '0); // R6
  AST_LEVEL_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_hold_i && !pwr_down_i) |=> acc_q == '0); // R7
  AST_PD_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_down_i |=> $stable(acc_q) && $stable(act_ftw)); // R10
endmodule

bind dds_phase_acc dds_phase_acc_chk #(.PHASE_W(PHASE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ftw_wr_i     (ftw_wr_i),
  .ftw_i        (ftw_i),
  .update_i     (update_i),
  .auto_clr_en_i(auto_clr_en_i),
  .clr_hold_i   (clr_hold_i),
  .pwr_down_i   (pwr_down_i),
  .hold_ftw     (hold_ftw),
  .act_ftw      (act_ftw),
  .acc_q        (acc_q)
);

// File: tb/dds_phase_acc_tb.sv
module dds_phase_acc_tb;
  localparam int unsigned W = 32;
  localparam logic [W-1:0] QTR = 32'h4000_0000;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         ftw_wr_i = 1'b0;
  logic [W-1:0] ftw_i = '0;
  logic         update_i = 1'b0;
  logic         auto_clr_en_i = 1'b0;
  logic         clr_hold_i = 1'b0;
  logic         sine_sel_i = 1'b0;
  logic         pwr_down_i = 1'b0;
  logic [W-1:0] phase_o;
  logic         sine_sel_o;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] m_acc = '0, m_hold = '0, m_act = '0;

  always #10 clk_i = ~clk_i; // 50 MHz

  dds_phase_acc #(.PHASE_W(W)) u_dut (.*);

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock: model advances at rising edge, compare at falling edge
  task automatic cycle(string req);
    @(posedge clk_i);
    if (!pwr_down_i) begin
      if (clr_hold_i)                         m_acc = '0;
      else if (update_i && auto_clr_en_i)     m_acc = '0;
      else                                    m_acc = m_acc + m_act;
      if (update_i) m_act = m_hold;
    end
    if (ftw_wr_i) m_hold = ftw_i;
    @(negedge clk_i);
    chk(req, phase_o, sine_sel_i ? m_acc - QTR : m_acc);
    chk(req, {{(W-1){1'b0}}, sine_sel_o}, {{(W-1){1'b0}}, sine_sel_i});
  endtask

  task automatic stage(logic [W-1:0] v, string req);
    ftw_wr_i = 1'b1; ftw_i = v;
    cycle(req);
    ftw_wr_i = 1'b0;
  endtask

  task automatic strobe(string req);
    update_i = 1'b1;
    cycle(req);
    update_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", phase_o, '0);
    chk("R1", {{(W-1){1'b0}}, sine_sel_o}, '0);
    for (int i = 0; i < 3; i++) cycle("R1");
  endtask

  task automatic t_stage_only;
    stage(32'h0000_0100, "R3");
    for (int i = 0; i < 4; i++) cycle("R3");
    chk("R3", phase_o, '0);
  endtask

  task automatic t_update_plain;
    auto_clr_en_i = 1'b0;
    strobe("R4");
    chk("R4", phase_o, '0); // old word (0) still used on the update edge
    cycle("R4");
    chk("R4", phase_o, 32'h0000_0100);
    for (int i = 0; i < 5; i++) cycle("R2");
    chk("R2", phase_o, 32'h0000_0600);
    stage(32'h0000_0010, "R3");
    strobe("R5");
    chk("R5", phase_o, 32'h0000_0800); // no reset, stepped twice more by 0x100
    cycle("R5");
    chk("R5", phase_o, 32'h0000_0810);
  endtask

  task automatic t_wrap;
    stage(32'hC000_0000, "R2");
    strobe("R2");
    for (int i = 0; i < 6; i++) cycle("R2");
  endtask

  task automatic t_auto_clear;
    auto_clr_en_i = 1'b1;
    for (int i = 0; i < 2; i++) cycle("R6");
    stage(32'h0000_0030, "R6");
    strobe("R6");
    chk("R6", phase_o, '0);
    cycle("R6");
    chk("R6", phase_o, 32'h0000_0030);
    cycle("R6");
    chk("R6", phase_o, 32'h0000_0060);
  endtask

  task automatic t_level_clear;
    clr_hold_i = 1'b1;
    update_i = 1'b1;
    cycle("R7");
    update_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      cycle("R7");
      chk("R7", phase_o, '0);
    end
    clr_hold_i = 1'b0;
    cycle("R7");
    chk("R7", phase_o, 32'h0000_0030);
    auto_clr_en_i = 1'b0;
  endtask

  task automatic t_sine;
    sine_sel_i = 1'b1;
    for (int i = 0; i < 3; i++) cycle("R9");
    clr_hold_i = 1'b1;
    cycle("R9");
    chk("R9", phase_o, 32'hC000_0000);
    clr_hold_i = 1'b0;
    sine_sel_i = 1'b0;
    cycle("R8");
    chk("R8", phase_o, 32'h0000_0030);
  endtask

  task automatic t_power_down;
    logic [W-1:0] frozen;
    cycle("R10");
    frozen = phase_o;
    pwr_down_i = 1'b1;
    stage(32'h0000_0500, "R10");
    strobe("R10");
    clr_hold_i = 1'b1;
    cycle("R10");
    clr_hold_i = 1'b0;
    for (int i = 0; i < 2; i++) cycle("R10");
    chk("R10", phase_o, frozen);
    pwr_down_i = 1'b0;
    cycle("R10");
    chk("R10", phase_o, frozen + 32'h0000_0030); // active word untouched
    strobe("R10");
    cycle("R10");
    chk("R10", phase_o, frozen + 32'h0000_0060 + 32'h0000_0500); // staged write kept
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_stage_only();
    t_update_plain();
    t_wrap();
    t_auto_clear();
    t_level_clear();
    t_sine();
    t_power_down();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule